// File: doc/BRIEF.md
# USB 2.0 Transceiver Power Sequencer

This block is a hardware state machine that powers a USB 2.0 transceiver up and down, so that no software driver has to do it. Each change goes through a read-modify-write on a simple register bus. The bus has a request/acknowledge handshake, one access outstanding at a time, and a region select that picks either the transceiver register space or a miscellaneous control space.

A power-up request runs a fixed sequence. The sequencer sets the PLL dividers, enables the pull-up and takes the port out of suspend. On the OTG-capable variant it also powers the OTG module, turns off charger detection and removes the device-mode pull-downs. It then waits for four completion flags in a fixed order. Each wait re-reads its flag at a programmed interval and gives up after a programmed number of failed reads. A power-down request undoes the enables. A power-down sequence also runs by itself once after reset, so the transceiver starts powered down. The `otgMode` strap selects the variant. It must be held constant while the block is out of reset.

Top module: `usbphy_pwr_seq`

## Requirements
- R1: After reset is released, `busy` is high and the power-down sequence of R8 runs without any request. It ends with a `seqDone` pulse and `errCode` 0.
- R2: Each access keeps `busReq`, `busRegion` (0 = transceiver, 1 = control), `busAddr`, `busWe` and `busWdata` steady until `busAck`. Each register update is a read of a word followed directly by a write of the modified word to the same address.
- R3: The first power-up access is a read-modify-write of transceiver offset 0x00. It clears bits 6:0, 24:16 and 29:28, puts 5 into bits 6:0 and 96 into bits 24:16, and keeps every other bit.
- R4: Next, the control word gets bit 0 (pull-up) and the suspend-release bit set. The control word is at control offset 0x20 with that bit at bit 14 when `otgMode`=1, and at control offset 0x04 with that bit at bit 7 when `otgMode`=0.
- R5: With `otgMode`=1 only, three more updates follow in this order: set bit 4 at transceiver offset 0x34; clear bits 2, 3, 4, 5, 7, 12 and 13 at transceiver offset 0x38; clear bits 5 and 6 of the control word. With `otgMode`=0 none of these accesses happens.
- R6: The sequencer then polls transceiver registers, reads only, in this order: offset 0x08 bit 31, then offset 0x08 bit 23, then offset 0x18 bit 31, then offset 0x00 bit 31. A read that returns the bit set moves on to the next poll.
- R7: Consecutive reads of the same poll are at least `POLL_CYC` cycles apart. After `TIMEOUT_CYC/POLL_CYC` reads without the flag, the sequence ends with no further accesses. `errCode` then shows 1, 2, 3 or 4 for the first, second, third or fourth poll.
- R8: Power-down clears bit 0 and the variant's suspend-release bit of the control word. With `otgMode`=1 it then also clears bit 4 at transceiver offset 0x34. Power-down always ends with `errCode` 0.
- R9: Requests that arrive while `busy` is high are ignored. When the block is idle and both requests are high together, power-down is taken.
- R10: `seqDone` is a single-cycle pulse, and `busy` is low in that cycle. `errCode` holds its value until the next accepted request, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| otgMode | input | 1 | Variant strap: 1 = OTG-capable, 0 = host-only |
| pwrOnReq | input | 1 | Power-up request, taken when idle |
| pwrOffReq | input | 1 | Power-down request, taken when idle |
| busy | output | 1 | A sequence is running |
| seqDone | output | 1 | One-cycle pulse when a sequence ends |
| errCode | output | 3 | 0 = success, 1..4 = poll that timed out |
| busReq | output | 1 | Bus access request |
| busWe | output | 1 | 1 = write, 0 = read |
| busRegion | output | 1 | 0 = transceiver space, 1 = control space |
| busAddr | output | 8 | Byte offset within the region |
| busWdata | output | 32 | Write data |
| busRdata | input | 32 | Read data, valid with busAck |
| busAck | input | 1 | Access complete |

## Verification
The hardest case to reach from the ports is a timeout on a poll deep in the sequence. In that case the reads of the earlier polls must succeed after varied delays, and the failing poll must stop after exactly the allowed number of reads with no access behind it. The bus model therefore returns each completion flag as clear for a chosen number of reads, or forever, and counts the reads each poll receives. It also timestamps those reads so the spacing between retries can be checked. Requests pulsed in the middle of a running sequence, and both requests raised together when idle, cover the acceptance rules.

// File: rtl/usbphy_seq_pkg.sv
`timescale 1ns/1ps
package usbphy_seq_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  // register offsets used by the sequence
  localparam logic [ADDR_W-1:0] OFS_PLL      = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CAL      = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SQUELCH  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_OTGPWR   = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_CHARGER  = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_CTL_OTG  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CTL_HOST = 8'h04;

  // field values
  localparam logic [DATA_W-1:0] PLL_CLR_M    = 32'h31FF_007F;
  localparam logic [DATA_W-1:0] PLL_SET_M    = 32'h0060_0005;
  localparam logic [DATA_W-1:0] OTGPWR_M     = 32'h0000_0010;
  localparam logic [DATA_W-1:0] CHARGER_M    = 32'h0000_30BC;
  localparam logic [DATA_W-1:0] PULLDN_M     = 32'h0000_0060;
  localparam logic [DATA_W-1:0] PULLUP_M     = 32'h0000_0001;
  localparam logic [DATA_W-1:0] SUSP_OTG_M   = 32'h0000_4000;
  localparam logic [DATA_W-1:0] SUSP_HOST_M  = 32'h0000_0080;

  typedef enum logic [1:0] {K_END = 2'd0, K_RMW = 2'd1, K_POLL = 2'd2} stepKindE;

  typedef struct packed {
    stepKindE            kind;
    logic                misc;
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   setM;
    logic [DATA_W-1:0]   clrM;
    logic [4:0]          flagBit;
    logic [1:0]          waitId;
  } stepT;

  typedef struct packed {
    logic loadOn;
    logic loadOff;
    logic capture;
    logic stepInc;
    logic tryClr;
    logic tryInc;
    logic gapStart;
  } strobeT;

  function automatic stepT makeRmw(logic misc, logic [ADDR_W-1:0] addr,
                                   logic [DATA_W-1:0] setM, logic [DATA_W-1:0] clrM);
    stepT s;
    s = '0;
    s.kind = K_RMW;
    s.misc = misc;
    s.addr = addr;
    s.setM = setM;
    s.clrM = clrM;
    return s;
  endfunction

  function automatic stepT makePoll(logic [ADDR_W-1:0] addr, logic [4:0] flagBit,
                                    logic [1:0] waitId);
    stepT s;
    s = '0;
    s.kind = K_POLL;
    s.addr = addr;
    s.flagBit = flagBit;
    s.waitId = waitId;
    return s;
  endfunction

  // step descriptor for a given sequence, variant and step number
  function automatic stepT lookupStep(logic onSeq, logic otg, logic [3:0] idx);
    stepT s;
    logic [ADDR_W-1:0] ctlA;
    logic [DATA_W-1:0] suspM;
    int pollOfs;
    s = '0;
    ctlA = otg ? OFS_CTL_OTG : OFS_CTL_HOST;
    suspM = otg ? SUSP_OTG_M : SUSP_HOST_M;
    pollOfs = int'(idx) - (otg ? 5 : 2);
    if (onSeq) begin
      if (idx == 4'd0)             s = makeRmw(1'b0, OFS_PLL, PLL_SET_M, PLL_CLR_M);
      else if (idx == 4'd1)        s = makeRmw(1'b1, ctlA, suspM | PULLUP_M, '0);
      else if (otg && idx == 4'd2) s = makeRmw(1'b0, OFS_OTGPWR, OTGPWR_M, '0);
      else if (otg && idx == 4'd3) s = makeRmw(1'b0, OFS_CHARGER, '0, CHARGER_M);
      else if (otg && idx == 4'd4) s = makeRmw(1'b1, ctlA, '0, PULLDN_M);
      else begin
        case (pollOfs)
          0: s = makePoll(OFS_CAL, 5'd31, 2'd0);
          1: s = makePoll(OFS_CAL, 5'd23, 2'd1);
          2: s = makePoll(OFS_SQUELCH, 5'd31, 2'd2);
          3: s = makePoll(OFS_PLL, 5'd31, 2'd3);
          default: s = '0;
        endcase
      end
    end else begin
      if (idx == 4'd0)             s = makeRmw(1'b1, ctlA, '0, suspM | PULLUP_M);
      else if (otg && idx == 4'd1) s = makeRmw(1'b0, OFS_OTGPWR, '0, OTGPWR_M);
    end
    return s;
  endfunction

endpackage

// File: rtl/usbphy_seq_dp.sv
`timescale 1ns/1ps
module usbphy_seq_dp
  import usbphy_seq_pkg::*;
#(
  parameter int POLL_CYC    = 2500000,
  parameter int TIMEOUT_CYC = 250000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              otgMode,
  input  strobeT            stb,
  input  logic [DATA_W-1:0] busRdata,
  output stepKindE          stepKind,
  output logic              flagNow,
  output logic              triesLast,
  output logic              gapDone,
  output logic [1:0]        waitId,
  output logic              busRegion,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata
);

  localparam int MAX_TRIES = (TIMEOUT_CYC / POLL_CYC < 1) ? 1 : TIMEOUT_CYC / POLL_CYC;
  localparam int TRY_W     = $clog2(MAX_TRIES + 1);

  logic [3:0]        stepIdx;
  logic              onSel;
  logic [DATA_W-1:0] capWord;
  logic [TRY_W-1:0]  tryCnt;
  stepT              cur;

  always_comb cur = lookupStep(onSel, otgMode, stepIdx);

  assign stepKind  = cur.kind;
  assign waitId    = cur.waitId;
  assign busRegion = cur.misc;
  assign busAddr   = cur.addr;
  assign busWdata  = (capWord & ~cur.clrM) | cur.setM;
  assign flagNow   = busRdata[cur.flagBit];
  assign triesLast = (tryCnt == TRY_W'(MAX_TRIES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepIdx <= '0;
      onSel   <= 1'b0;
      capWord <= '0;
      tryCnt  <= '0;
    end else begin
      if (stb.loadOn || stb.loadOff) begin
        stepIdx <= '0;
        onSel   <= stb.loadOn && !stb.loadOff;
      end else if (stb.stepInc) begin
        stepIdx <= stepIdx + 4'd1;
      end
      if (stb.capture) capWord <= busRdata;
      if (stb.tryClr)      tryCnt <= '0;
      else if (stb.tryInc) tryCnt <= tryCnt + TRY_W'(1);
    end
  end

  generate
    if (POLL_CYC > 1) begin : g_gap
      localparam int GAP_W = $clog2(POLL_CYC + 1);
      logic [GAP_W-1:0] gapCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  gapCnt <= '0;
        else if (stb.gapStart)      gapCnt <= GAP_W'(POLL_CYC - 1);
        else if (gapCnt != '0)      gapCnt <= gapCnt - GAP_W'(1);
      end
      assign gapDone = (gapCnt == '0);
    end else begin : g_nogap
      assign gapDone = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/usbphy_seq_ctrl.sv
`timescale 1ns/1ps
module usbphy_seq_ctrl
  import usbphy_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrOnReq,
  input  logic       pwrOffReq,
  input  logic       busAck,
  input  stepKindE   stepKind,
  input  logic       flagNow,
  input  logic       triesLast,
  input  logic       gapDone,
  input  logic [1:0] waitId,
  output strobeT     stb,
  output logic       busReq,
  output logic       busWe,
  output logic       busy,
  output logic       seqDone,
  output logic [2:0] errCode
);

  typedef enum logic [2:0] {S_IDLE, S_NEXT, S_RD, S_WR, S_GAP} stateE;

  stateE state, nxt;
  logic  accept, finish, fail;

  always_comb begin
    nxt    = state;
    stb    = '0;
    busReq = 1'b0;
    busWe  = 1'b0;
    accept = 1'b0;
    finish = 1'b0;
    fail   = 1'b0;
    case (state)
      S_IDLE: begin
        if (pwrOffReq) begin
          stb.loadOff = 1'b1;
          accept      = 1'b1;
          nxt         = S_NEXT;
        end else if (pwrOnReq) begin
          stb.loadOn = 1'b1;
          accept     = 1'b1;
          nxt        = S_NEXT;
        end
      end
      S_NEXT: begin
        stb.tryClr = 1'b1;
        if (stepKind == K_END) begin
          finish = 1'b1;
          nxt    = S_IDLE;
        end else begin
          nxt = S_RD;
        end
      end
      S_RD: begin
        busReq = 1'b1;
        if (busAck) begin
          if (stepKind == K_RMW) begin
            stb.capture = 1'b1;
            nxt         = S_WR;
          end else if (flagNow) begin
            stb.stepInc = 1'b1;
            nxt         = S_NEXT;
          end else if (triesLast) begin
            finish = 1'b1;
            fail   = 1'b1;
            nxt    = S_IDLE;
          end else begin
            stb.tryInc   = 1'b1;
            stb.gapStart = 1'b1;
            nxt          = S_GAP;
          end
        end
      end
      S_WR: begin
        busReq = 1'b1;
        busWe  = 1'b1;
        if (busAck) begin
          stb.stepInc = 1'b1;
          nxt         = S_NEXT;
        end
      end
      S_GAP: begin
        if (gapDone) nxt = S_RD;
      end
      default: nxt = S_IDLE;
    endcase
  end

  // reset lands in S_NEXT with the power-down sequence selected
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_NEXT;
      seqDone <= 1'b0;
      errCode <= 3'd0;
    end else begin
      state   <= nxt;
      seqDone <= finish;
      if (accept)    errCode <= 3'd0;
      else if (fail) errCode <= {1'b0, waitId} + 3'd1;
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/usbphy_pwr_seq.sv
`timescale 1ns/1ps
module usbphy_pwr_seq
  import usbphy_seq_pkg::*;
#(
  parameter int POLL_CYC    = 2500000,
  parameter int TIMEOUT_CYC = 250000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              otgMode,
  input  logic              pwrOnReq,
  input  logic              pwrOffReq,
  output logic              busy,
  output logic              seqDone,
  output logic [2:0]        errCode,
  output logic              busReq,
  output logic              busWe,
  output logic              busRegion,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busAck
);

  strobeT     stb;
  stepKindE   stepKind;
  logic       flagNow, triesLast, gapDone;
  logic [1:0] waitId;

  usbphy_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pwrOnReq  (pwrOnReq),
    .pwrOffReq (pwrOffReq),
    .busAck    (busAck),
    .stepKind  (stepKind),
    .flagNow   (flagNow),
    .triesLast (triesLast),
    .gapDone   (gapDone),
    .waitId    (waitId),
    .stb       (stb),
    .busReq    (busReq),
    .busWe     (busWe),
    .busy      (busy),
    .seqDone   (seqDone),
    .errCode   (errCode)
  );

  usbphy_seq_dp #(
    .POLL_CYC    (POLL_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .otgMode   (otgMode),
    .stb       (stb),
    .busRdata  (busRdata),
    .stepKind  (stepKind),
    .flagNow   (flagNow),
    .triesLast (triesLast),
    .gapDone   (gapDone),
    .waitId    (waitId),
    .busRegion (busRegion),
    .busAddr   (busAddr),
    .busWdata  (busWdata)
  );

endmodule

// File: rtl/usbphy_seq_chk.sv
`timescale 1ns/1ps
module usbphy_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        seqDone,
  input logic [2:0]  errCode,
  input logic        busReq,
  input logic        busWe,
  input logic        busAck,
  input logic        busRegion,
  input logic [7:0]  busAddr,
  input logic [31:0] busWdata
);

  // R2: a pending access keeps all its fields until acknowledged
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busRegion)
                          && $stable(busWe) && $stable(busWdata));

  // R2: a write starts right after an acknowledged read of the same register
  a_r2_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busWe && !$past(busWe) |->
      $past(busReq) && $past(busAck) && $past(busAddr) == busAddr
      && $past(busRegion) == busRegion);

  // R9: no bus traffic while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busReq);

  // R10: completion pulse only when idle, and it lasts one cycle
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> !busy);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);

  // R10: error code holds while idle
  a_r10_err_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !seqDone |-> $stable(errCode));

  // R7: only codes 0..4 are reported
  a_r7_err_range: assert property (@(posedge clk) disable iff (!rstN)
    errCode <= 3'd4);

endmodule

bind usbphy_pwr_seq usbphy_seq_chk u_chk (.*);

// File: tb/test_usbphy_pwr_seq.sv
`timescale 1ns/1ps
module test_usbphy_pwr_seq;

  localparam int POLL = 6;
  localparam int TOUT = 24;
  localparam int MAXT = TOUT / POLL;

  typedef struct packed {
    logic        misc;
    logic [7:0]  addr;
    logic        we;
    logic [31:0] data;
    logic [2:0]  pollId;
    logic [3:0]  req;
  } itemT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        otgMode = 1'b0;
  logic        pwrOnReq = 1'b0;
  logic        pwrOffReq = 1'b0;
  logic        busy, seqDone, busReq, busWe, busRegion;
  logic [2:0]  errCode;
  logic [7:0]  busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata = '0;
  logic        busAck = 1'b0;

  logic [31:0] phyMem [64];
  logic [31:0] miscMem [64];
  logic [31:0] expPhy [64];
  logic [31:0] expMisc [64];
  itemT        expQ [$];
  itemT        curIt;
  int          need [4];
  int          seen [4];
  int          lastCyc [4];
  int          cyc = 0;
  int          nVec = 0;
  int          nMis = 0;
  bit          ended = 0;

  always #2 clk = ~clk;

  usbphy_pwr_seq #(.POLL_CYC(POLL), .TIMEOUT_CYC(TOUT)) i_usbphy_pwr_seq (
    .clk(clk), .rstN(rstN), .otgMode(otgMode), .pwrOnReq(pwrOnReq),
    .pwrOffReq(pwrOffReq), .busy(busy), .seqDone(seqDone), .errCode(errCode),
    .busReq(busReq), .busWe(busWe), .busRegion(busRegion), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (!ok) begin
      nMis++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nMis);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nMis++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      summary();
    end
  end

  // bus model and scoreboard monitor
  always @(negedge clk) begin
    logic [31:0] rd;
    int k;
    if (!rstN) begin
      busAck <= 1'b0;
    end else if (busAck) begin
      busAck <= 1'b0;
    end else if (busReq) begin
      busAck <= 1'b1;
      k = 7;
      if (expQ.size() == 0) begin
        check(0, "R9", "unexpected access", {22'b0, busRegion, busWe, busAddr}, 32'h0);
      end else begin
        curIt = expQ.pop_front();
        k = int'(curIt.pollId);
        check(busRegion == curIt.misc && busAddr == curIt.addr && busWe == curIt.we,
              $sformatf("R%0d", curIt.req), "region/we/addr",
              {22'b0, busRegion, busWe, busAddr}, {22'b0, curIt.misc, curIt.we, curIt.addr});
        if (curIt.we)
          check(busWdata == curIt.data, $sformatf("R%0d", curIt.req), "write data",
                busWdata, curIt.data);
      end
      if (busWe) begin
        if (busRegion) miscMem[busAddr[7:2]] = busWdata;
        else           phyMem[busAddr[7:2]] = busWdata;
      end else begin
        rd = busRegion ? miscMem[busAddr[7:2]] : phyMem[busAddr[7:2]];
        if (k < 4) begin
          // R7: retry spacing
          if (seen[k] > 0)
            check(cyc - lastCyc[k] >= POLL, "R7", "poll spacing", cyc - lastCyc[k], POLL);
          lastCyc[k] = cyc;
          rd[(k == 1) ? 23 : 31] = (seen[k] >= need[k]);
          seen[k]++;
        end
        busRdata <= rd;
      end
    end
  end

  function automatic logic [31:0] shGet(input bit misc, input logic [7:0] a);
    return misc ? expMisc[a[7:2]] : expPhy[a[7:2]];
  endfunction

  task automatic push(input bit misc, input logic [7:0] a, input bit we,
                      input logic [31:0] d, input int pid, input int req);
    itemT it;
    it.misc = misc; it.addr = a; it.we = we; it.data = d;
    it.pollId = 3'(pid); it.req = 4'(req);
    expQ.push_back(it);
  endtask

  task automatic expRmw(input bit misc, input logic [7:0] a, input logic [31:0] setM,
                        input logic [31:0] clrM, input int req);
    logic [31:0] v, nv;
    v = shGet(misc, a);
    nv = (v & ~clrM) | setM;
    push(misc, a, 0, v, 7, req);
    push(misc, a, 1, nv, 7, req);
    if (misc) expMisc[a[7:2]] = nv;
    else      expPhy[a[7:2]] = nv;
  endtask

  function automatic logic [7:0] ctlOf(input bit otg);
    return otg ? 8'h20 : 8'h04;
  endfunction

  function automatic logic [31:0] suspOf(input bit otg);
    return otg ? 32'h4000 : 32'h80;
  endfunction

  // R8: expected power-down accesses
  task automatic expOff(input bit otg);
    expRmw(1, ctlOf(otg), 32'h0, suspOf(otg) | 32'h1, 8);
    if (otg) expRmw(0, 8'h34, 32'h0, 32'h10, 8);
  endtask

  // R3 R4 R5 R6 R7: expected power-up accesses, returns expected error code
  task automatic expOn(input bit otg, input int n0, input int n1, input int n2,
                       input int n3, output int err);
    logic [7:0] pa [4];
    pa[0] = 8'h08; pa[1] = 8'h08; pa[2] = 8'h18; pa[3] = 8'h00;
    need[0] = n0; need[1] = n1; need[2] = n2; need[3] = n3;
    for (int i = 0; i < 4; i++) seen[i] = 0;
    expRmw(0, 8'h00, 32'h0060_0005, 32'h31FF_007F, 3);
    expRmw(1, ctlOf(otg), suspOf(otg) | 32'h1, 32'h0, 4);
    if (otg) begin
      expRmw(0, 8'h34, 32'h10, 32'h0, 5);
      expRmw(0, 8'h38, 32'h0, 32'h30BC, 5);
      expRmw(1, ctlOf(otg), 32'h0, 32'h60, 5);
    end
    err = 0;
    for (int k = 0; k < 4; k++) begin
      if (err == 0) begin
        int nr;
        nr = (need[k] < MAXT) ? need[k] + 1 : MAXT;
        for (int r = 0; r < nr; r++) push(0, pa[k], 0, 32'h0, k, 6);
        if (need[k] >= MAXT) err = k + 1;
      end
    end
  endtask

  task automatic waitDone(input int expErr, input string req);
    int t;
    t = 0;
    while (!seqDone && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(seqDone, "R10", "done pulse seen", {31'b0, seqDone}, 32'h1);
    check(!busy, "R10", "busy low with done", {31'b0, busy}, 32'h0);
    check(errCode == 3'(expErr), req, "error code", {29'b0, errCode}, expErr);
    check(expQ.size() == 0, req, "accesses left over", expQ.size(), 32'h0);
    @(negedge clk);
    check(!seqDone, "R10", "done lasts one cycle", {31'b0, seqDone}, 32'h0);
    repeat (12) @(negedge clk);
    check(expQ.size() == 0 && !busy, "R7", "quiet after end", {31'b0, busy}, 32'h0);
  endtask

  task automatic pulseReq(input bit on, input bit off);
    pwrOnReq = on;
    pwrOffReq = off;
    @(negedge clk);
    pwrOnReq = 1'b0;
    pwrOffReq = 1'b0;
  endtask

  // R1: reset and automatic power-down
  task automatic doReset(input bit otg);
    rstN = 1'b0;
    otgMode = otg;
    expQ.delete();
    for (int i = 0; i < 64; i++) begin
      phyMem[i]  = 32'h9E37_79B9 * (i + 1);
      miscMem[i] = 32'hFFFF_FFFF ^ (32'h0101_0101 * i);
      expPhy[i]  = phyMem[i];
      expMisc[i] = miscMem[i];
    end
    for (int i = 0; i < 4; i++) begin seen[i] = 0; need[i] = 0; end
    expOff(otg);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy, "R1", "busy after reset", {31'b0, busy}, 32'h1);
    waitDone(0, "R1");
  endtask

  initial begin
    int e;
    @(negedge clk);
    check(!seqDone && !busReq && errCode == 3'd0, "R1", "outputs in reset",
          {28'b0, seqDone, busReq, errCode[1:0]}, 32'h0);

    // host-only variant
    doReset(0);
    expOn(0, 0, 1, 2, 0, e);                 // R6 varied delays, success
    pulseReq(1, 0);
    waitDone(e, "R6");

    expOn(0, 1, 0, 0, 1, e);                 // R9 requests while busy ignored
    pulseReq(1, 0);
    repeat (8) @(negedge clk);
    check(busy, "R9", "busy mid-sequence", {31'b0, busy}, 32'h1);
    pulseReq(1, 1);
    pulseReq(0, 1);
    waitDone(e, "R9");

    expOff(0);                               // R8 host power-down
    pulseReq(0, 1);
    waitDone(0, "R8");

    expOn(0, 0, 0, 99, 0, e);                // R7 third poll never completes
    pulseReq(1, 0);
    waitDone(e, "R7");
    check(seen[2] == MAXT, "R7", "reads on timed-out poll", seen[2], MAXT);

    expOn(0, 99, 0, 0, 0, e);                // R7 first poll never completes
    pulseReq(1, 0);
    waitDone(e, "R7");

    // OTG variant
    doReset(1);
    expOn(1, 1, 0, 3, 0, e);                 // R5 extra steps
    pulseReq(1, 0);
    waitDone(e, "R5");

    expOn(1, 0, 2, 0, 99, e);                // R7 last poll never completes
    pulseReq(1, 0);
    waitDone(e, "R7");
    repeat (5) @(negedge clk);
    check(errCode == 3'd4, "R10", "error code held", {29'b0, errCode}, 32'h4);

    expOff(1);                               // R9 off wins when both raised
    pulseReq(1, 1);
    waitDone(0, "R8");

    summary();
  end

endmodule